// File: doc/BRIEF.md
# Bus-Attached Serial Port with Transmit and Receive Queues

This block is a UART slave on a 32-bit AHB-Lite bus. Software writes a byte to the data word, and the byte goes into a transmit queue. A serialiser drains that queue on its own and sends each byte as an asynchronous frame on the outgoing line. On the incoming line, a deserialiser recovers frames, checks them, and stores the good bytes in a receive queue. Software reads the same data word to pop the oldest received byte, and polls a status word to see the queue state.

The block decodes a 16 MB window whose base is a parameter. The default base is 0x5100_0000. A divider makes a tick at sixteen times the line rate from the system clock. The defaults are a 50 MHz clock and 19200 bit/s. A frame has one low start bit, eight data bits (least significant bit first), an optional even-parity bit selected by a parameter, and one high stop bit. Every bus access completes in one data phase with an OKAY response.

Top module: `ahbl_serial_port`

## Requirements
- R1: A write to offset 0x0 places bits [7:0] of the write data in the transmit queue. Queued bytes leave on `uart_tx` in write order. Each frame is a low start bit, then data bit 0 through bit 7, then (with parity enabled) a bit equal to the XOR of the eight data bits, then a high stop bit.
- R2: A read of offset 0x4 returns bit 0 = 1 when the receive queue is empty and bit 1 = 1 when the transmit queue is full. All other bits read as zero.
- R3: A write to offset 0x0 while the transmit queue is full is discarded, and the bytes already queued are sent unchanged. `hreadyout` is always 1 and `hresp` is always 0 (OKAY).
- R4: A read of offset 0x0 while the receive queue is empty returns 0.
- R5: A correctly framed incoming byte is stored, and reads of offset 0x0 return stored bytes oldest first. Each read removes one byte.
- R6: An incoming frame whose parity bit does not give even parity over the data and parity bits is discarded.
- R7: An incoming frame whose stop bit samples low is discarded.
- R8: A low pulse on `uart_rx` shorter than half a bit period does not start a frame.
- R9: An access takes effect only when `hsel`, `hready` and `htrans[1]` are all 1 in the address phase. IDLE (00) and BUSY (01) transfers, or `hsel` = 0, neither queue a byte nor remove one.
- R10: Every data bit on `uart_tx` lasts exactly OVS × floor(CLK_HZ / (BAUD × OVS)) clock cycles.
- R11: After reset `uart_tx` is 1, and the status word reads 0x1. Whenever the transmitter is idle, `uart_tx` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | System clock |
| hresetn | input | 1 | Synchronous active-low reset |
| hsel | input | 1 | Slave select from the address decoder |
| haddr | input | 32 | Address-phase byte address |
| htrans | input | 2 | Transfer type; bit 1 marks NONSEQ/SEQ |
| hwrite | input | 1 | 1 = write transfer |
| hready | input | 1 | Bus-wide ready; the previous transfer has ended |
| hwdata | input | 32 | Data-phase write data; bits [7:0] used |
| hrdata | output | 32 | Data-phase read data |
| hreadyout | output | 1 | Slave ready, constantly 1 |
| hresp | output | 1 | Response, constantly OKAY (0) |
| uart_rx | input | 1 | Incoming serial line, idle high |
| uart_tx | output | 1 | Outgoing serial line, idle high |

## Verification
The hardest condition to reach is a full transmit queue. The serialiser pops the first byte one cycle after it is written, so the queue never fills at the pace of a single frame. The bench writes queue-depth-plus-two bytes in consecutive bus transfers, well inside one frame time. It then reads the status word to see the full flag, and decodes the frames that follow to show the last byte was dropped. Bad-parity, bad-stop and glitch frames cannot come from the block's own transmitter, so the bench drives them on the incoming line with exact bit timing.

// File: rtl/serial_pkg.sv
// Shared types and helpers for the bus-attached serial port.
// Assumes: frames carry exactly eight data bits.
package serial_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        LN_IDLE,
        LN_START,
        LN_DATA,
        LN_PARITY,
        LN_STOP
    } line_state_t;

    // Even-parity bit for one byte: makes the count of ones even.
    function automatic logic even_bit(input logic [BYTE_W-1:0] b);
        return ^b;
    endfunction

endpackage

// File: rtl/tick_gen.sv
// Free-running divider. It gives a one-cycle pulse every DIV clocks, which is the oversampling tick.
// Assumes: DIV >= 2.
module tick_gen #(
    parameter int DIV = 162
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    // Count to DIV-1, then wrap and pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/byte_queue.sv
// Synchronous first-in first-out store with show-ahead read data.
// Assumes: DEPTH is a power of two; push is ignored when full, pop is ignored when empty.
module byte_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [W-1:0]              wdata,
    input  logic                      pop,
    output logic [W-1:0]              rdata,
    output logic                      full,
    output logic                      empty,
    output logic [$clog2(DEPTH):0]    level
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW:0]   wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign level   = wr_ptr - rd_ptr;
    assign full    = (level == (AW+1)'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr[AW-1:0]];

    // Move the pointers on accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Write the storage array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr[AW-1:0]] <= wdata;
    end
endmodule

// File: rtl/serial_tx.sv
// Serialiser. It takes bytes from a queue and sends start, data (LSB first), optional even parity and stop.
// Assumes: tick is the oversampling pulse; each bit lasts OVS ticks.
module serial_tx
    import serial_pkg::*;
#(
    parameter int OVS       = 16,
    parameter bit PARITY_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              q_empty,
    input  logic [BYTE_W-1:0] q_data,
    output logic              q_pop,
    output logic              txd,
    output logic              busy
);
    localparam int TW = $clog2(OVS);

    line_state_t        state;
    logic [TW-1:0]      tcnt;
    logic [2:0]         bidx;
    logic [BYTE_W-1:0]  shreg;
    logic               pbit;
    logic               line_nxt;

    assign q_pop = (state == LN_IDLE) && !q_empty;
    assign busy  = (state != LN_IDLE);

    // Sequence through the frame; each bit ends after OVS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LN_IDLE;
            tcnt  <= '0;
            bidx  <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
        end else if (state == LN_IDLE) begin
            tcnt <= '0;
            bidx <= '0;
            if (!q_empty) begin
                shreg <= q_data;
                pbit  <= even_bit(q_data);
                state <= LN_START;
            end
        end else if (tick) begin
            if (tcnt == TW'(OVS - 1)) begin
                tcnt <= '0;
                unique case (state)
                    LN_START:  state <= LN_DATA;
                    LN_DATA: begin
                        shreg <= shreg >> 1;
                        bidx  <= bidx + 1'b1;
                        if (bidx == 3'd7) state <= PARITY_EN ? LN_PARITY : LN_STOP;
                    end
                    LN_PARITY: state <= LN_STOP;
                    default:   state <= LN_IDLE;
                endcase
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    // Line level for the current frame position.
    always_comb begin
        unique case (state)
            LN_START:  line_nxt = 1'b0;
            LN_DATA:   line_nxt = shreg[0];
            LN_PARITY: line_nxt = pbit;
            default:   line_nxt = 1'b1;
        endcase
    end

    // Register the line so the output pin cannot glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) txd <= 1'b1;
        else        txd <= line_nxt;
    end
endmodule

// File: rtl/serial_rx.sv
// Deserialiser. It finds a falling edge, confirms the start bit at mid-bit, samples each bit at its centre,
// and emits only frames with correct parity and stop.
// Assumes: rxd is asynchronous and passes a two-flop synchroniser here.
module serial_rx
    import serial_pkg::*;
#(
    parameter int OVS       = 16,
    parameter bit PARITY_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    output logic              push,
    output logic [BYTE_W-1:0] data
);
    localparam int TW   = $clog2(OVS);
    localparam int HALF = OVS / 2;

    line_state_t   state;
    logic [TW-1:0] tcnt;
    logic [2:0]    bidx;
    logic          sync1, sync2, prev;
    logic          pbit;
    logic          bit_end;

    assign bit_end = tick && (tcnt == TW'(OVS - 1));

    // Synchronise the line and keep one cycle of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
            prev  <= 1'b1;
        end else begin
            sync1 <= rxd;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    // Frame recovery and acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LN_IDLE;
            tcnt  <= '0;
            bidx  <= '0;
            data  <= '0;
            pbit  <= 1'b0;
            push  <= 1'b0;
        end else begin
            push <= 1'b0;
            unique case (state)
                LN_IDLE: begin
                    tcnt <= '0;
                    bidx <= '0;
                    if (prev && !sync2) state <= LN_START;
                end
                LN_START: if (tick) begin
                    if (tcnt == TW'(HALF - 1)) begin
                        tcnt  <= '0;
                        state <= sync2 ? LN_IDLE : LN_DATA;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: if (tick) begin
                    tcnt <= bit_end ? '0 : tcnt + 1'b1;
                    if (bit_end) begin
                        if (state == LN_DATA) begin
                            data <= {sync2, data[BYTE_W-1:1]};
                            bidx <= bidx + 1'b1;
                            if (bidx == 3'd7) state <= PARITY_EN ? LN_PARITY : LN_STOP;
                        end else if (state == LN_PARITY) begin
                            pbit  <= sync2;
                            state <= LN_STOP;
                        end else begin
                            push  <= sync2 && (!PARITY_EN || (even_bit(data) == pbit));
                            state <= LN_IDLE;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/ahbl_serial_port.sv
// AHB-Lite serial port slave. It captures the address phase, then pushes or pops a queue in the data phase.
// Offset 0x0 is data and offset 0x4 is status. Assumes: zero wait states, OKAY only.
module ahbl_serial_port
    import serial_pkg::*;
#(
    parameter logic [31:0] BASE       = 32'h5100_0000,
    parameter int          CLK_HZ     = 50_000_000,
    parameter int          BAUD       = 19_200,
    parameter int          OVS        = 16,
    parameter int          FIFO_DEPTH = 8,
    parameter bit          PARITY_EN  = 1'b1
) (
    input  logic        hclk,
    input  logic        hresetn,
    input  logic        hsel,
    input  logic [31:0] haddr,
    input  logic [1:0]  htrans,
    input  logic        hwrite,
    input  logic        hready,
    input  logic [31:0] hwdata,
    output logic [31:0] hrdata,
    output logic        hreadyout,
    output logic        hresp,
    input  logic        uart_rx,
    output logic        uart_tx
);
    localparam int DIV = CLK_HZ / (BAUD * OVS);
    localparam int LW  = $clog2(FIFO_DEPTH) + 1;

    logic              hit, dp_valid, dp_write, dp_data, dp_stat;
    logic              dp_read_data;
    logic              tick;
    logic              tx_push, tx_pop, tx_full, tx_empty, tx_busy;
    logic              rx_push, rx_pop, rx_full, rx_empty;
    logic [BYTE_W-1:0] tx_head, rx_head, rx_byte;
    logic [LW-1:0]     tx_level, rx_level;
    logic              unused_bits;

    assign unused_bits = ^{hwdata[31:8], haddr[1:0], rx_full};

    assign hit = hsel && hready && htrans[1] && (haddr[31:24] == BASE[31:24]);

    // Capture the address phase for use in the next data phase.
    always_ff @(posedge hclk) begin
        if (!hresetn) begin
            dp_valid <= 1'b0;
            dp_write <= 1'b0;
            dp_data  <= 1'b0;
            dp_stat  <= 1'b0;
        end else if (hready) begin
            dp_valid <= hit;
            dp_write <= hwrite;
            dp_data  <= (haddr[23:2] == 22'd0);
            dp_stat  <= (haddr[23:2] == 22'd1);
        end
    end

    assign dp_read_data = dp_valid && !dp_write && dp_data;
    assign tx_push      = dp_valid && dp_write && dp_data;
    assign rx_pop       = dp_read_data;
    assign hreadyout    = 1'b1;
    assign hresp        = 1'b0;

    // Data-phase read mux.
    always_comb begin
        hrdata = '0;
        if (dp_read_data && !rx_empty)           hrdata = {24'd0, rx_head};
        else if (dp_valid && !dp_write && dp_stat) hrdata = {30'd0, tx_full, rx_empty};
    end

    tick_gen #(.DIV(DIV)) u_tick (.clk(hclk), .rst_n(hresetn), .tick(tick));

    byte_queue #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(hclk), .rst_n(hresetn), .push(tx_push), .wdata(hwdata[7:0]),
        .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty), .level(tx_level));

    byte_queue #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(hclk), .rst_n(hresetn), .push(rx_push), .wdata(rx_byte),
        .pop(rx_pop), .rdata(rx_head), .full(rx_full), .empty(rx_empty), .level(rx_level));

    serial_tx #(.OVS(OVS), .PARITY_EN(PARITY_EN)) u_ser (
        .clk(hclk), .rst_n(hresetn), .tick(tick), .q_empty(tx_empty), .q_data(tx_head),
        .q_pop(tx_pop), .txd(uart_tx), .busy(tx_busy));

    serial_rx #(.OVS(OVS), .PARITY_EN(PARITY_EN)) u_des (
        .clk(hclk), .rst_n(hresetn), .tick(tick), .rxd(uart_rx),
        .push(rx_push), .data(rx_byte));
endmodule

// File: rtl/serial_port_chk.sv
// Property checker for the serial port, attached to every instance of the top through bind.
// Assumes: sampled on the rising edge of hclk, checks off while hresetn is low.
module serial_port_chk #(
    parameter int FIFO_DEPTH = 8,
    parameter int LW         = 4
) (
    input logic          hclk,
    input logic          hresetn,
    input logic          hreadyout,
    input logic          hresp,
    input logic [31:0]   hrdata,
    input logic          uart_tx,
    input logic          tx_busy,
    input logic          tx_full,
    input logic          rx_empty,
    input logic          dp_read_data,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level
);
    // R3
    okay_ready_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        hreadyout && !hresp);

    // R3
    no_overflow_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        tx_level <= LW'(FIFO_DEPTH) && rx_level <= LW'(FIFO_DEPTH));

    // R2
    full_flag_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        tx_full == (tx_level == LW'(FIFO_DEPTH)));

    // R4
    empty_read_zero_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        (dp_read_data && rx_empty) |-> (hrdata == 32'd0));

    // R11
    idle_line_high_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        !tx_busy |-> uart_tx);
endmodule

bind ahbl_serial_port serial_port_chk #(.FIFO_DEPTH(FIFO_DEPTH), .LW(LW)) u_chk (
    .hclk(hclk), .hresetn(hresetn), .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata),
    .uart_tx(uart_tx), .tx_busy(tx_busy), .tx_full(tx_full), .rx_empty(rx_empty),
    .dp_read_data(dp_read_data), .tx_level(tx_level), .rx_level(rx_level));

// File: tb/test_ahbl_serial_port.sv
// Self-checking bench for ahbl_serial_port. It uses a small divider, queue depth 4 and even parity.
module test_ahbl_serial_port;
    localparam int OVS   = 16;
    localparam int DIV   = 10;
    localparam int BIT   = OVS * DIV;
    localparam int DEPTH = 4;
    localparam logic [31:0] DATA_A = 32'h5100_0000;
    localparam logic [31:0] STAT_A = 32'h5100_0004;

    logic        hclk = 1'b0;
    logic        hresetn = 1'b0;
    logic        hsel = 1'b0;
    logic [31:0] haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic        hready = 1'b1;
    logic [31:0] hwdata = '0;
    logic [31:0] hrdata;
    logic        hreadyout, hresp, uart_tx;
    logic        loop = 1'b0;
    logic        bench_rx = 1'b1;
    logic        uart_rx;
    logic        bus_ok;
    int          n_chk = 0;
    int          n_bad = 0;

    assign uart_rx = loop ? uart_tx : bench_rx;

    always #5 hclk = ~hclk;

    ahbl_serial_port #(.CLK_HZ(1_600_000), .BAUD(10_000), .OVS(OVS),
                       .FIFO_DEPTH(DEPTH), .PARITY_EN(1'b1)) i_ahbl_serial_port (
        .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hready(hready), .hwdata(hwdata), .hrdata(hrdata),
        .hreadyout(hreadyout), .hresp(hresp), .uart_rx(uart_rx), .uart_tx(uart_tx));

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic sel, input logic [1:0] tr, input logic wr,
                       input logic [31:0] a, input logic [31:0] wd, output logic [31:0] rd);
        @(negedge hclk);
        hsel = sel; htrans = tr; hwrite = wr; haddr = a;
        @(negedge hclk);
        hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hwdata = wd;
        rd = hrdata;
        bus_ok = hreadyout && !hresp;
    endtask

    task automatic wr(input logic [31:0] a, input logic [7:0] b);
        logic [31:0] d;
        bus(1'b1, 2'b10, 1'b1, a, {24'hABCDEF, b}, d);
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        bus(1'b1, 2'b10, 1'b0, a, 32'd0, d);
    endtask

    // Wait for a start bit on uart_tx, then sample start, 8 data, parity and stop near their centres.
    task automatic grab(input int limit, output logic found, output logic [7:0] b,
                        output logic p, output logic s, output logic st);
        found = 1'b0; b = '0; p = 1'b0; s = 1'b0; st = 1'b1;
        for (int n = 0; n < limit; n++) begin
            @(negedge hclk);
            if (!uart_tx) begin found = 1'b1; break; end
        end
        if (found) begin
            repeat ((BIT - DIV) / 2 - 1) @(negedge hclk);
            st = uart_tx;
            for (int i = 0; i < 8; i++) begin
                repeat (BIT) @(negedge hclk);
                b[i] = uart_tx;
            end
            repeat (BIT) @(negedge hclk); p = uart_tx;
            repeat (BIT) @(negedge hclk); s = uart_tx;
        end
    endtask

    task automatic drive(input logic [7:0] b, input logic flip_par, input logic stop_val);
        @(negedge hclk); bench_rx = 1'b0;
        repeat (BIT) @(negedge hclk);
        for (int i = 0; i < 8; i++) begin
            bench_rx = b[i];
            repeat (BIT) @(negedge hclk);
        end
        bench_rx = (^b) ^ flip_par;
        repeat (BIT) @(negedge hclk);
        bench_rx = stop_val;
        repeat (BIT) @(negedge hclk);
        bench_rx = 1'b1;
        repeat (BIT) @(negedge hclk);
    endtask

    initial begin
        repeat (190_000) @(posedge hclk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        f, p, s, st;
        logic [7:0]  b, v;
        logic [7:0]  seq [4];
        int          n;
        seq[0] = 8'h55; seq[1] = 8'hA3; seq[2] = 8'h0F; seq[3] = 8'h80;

        repeat (4) @(negedge hclk);
        hresetn = 1'b1;
        @(negedge hclk);
        // R11 reset state
        chk(uart_tx == 1'b1, "R11 line idle after reset", {31'd0, uart_tx}, 32'd1);
        rd(STAT_A, d);
        chk(d == 32'h1, "R11 R2 status after reset", d, 32'h1);
        rd(DATA_A, d);
        chk(d == 32'h0, "R4 empty read returns zero", d, 32'h0);

        // R1 / R5: loopback of four bytes
        loop = 1'b1;
        for (int i = 0; i < 4; i++) wr(DATA_A, seq[i]);
        for (int i = 0; i < 4; i++) begin
            grab(4 * BIT, f, b, p, s, st);
            chk(f && !st && b == seq[i], "R1 frame data", {24'd0, b}, {24'd0, seq[i]});
            chk(p == ^seq[i] && s, "R1 parity and stop", {30'd0, p, s}, {30'd0, ^seq[i], 1'b1});
        end
        repeat (BIT) @(negedge hclk);
        rd(STAT_A, d);
        chk(d == 32'h0, "R2 status rx not empty", d, 32'h0);
        for (int i = 0; i < 4; i++) begin
            rd(DATA_A, d);
            chk(d == {24'd0, seq[i]}, "R5 loopback order", d, {24'd0, seq[i]});
        end
        rd(STAT_A, d);
        chk(d == 32'h1, "R2 status drained", d, 32'h1);

        // R10: bit period measured between bit0 rise and bit1 fall of 0x55
        wr(DATA_A, 8'h55);
        while (uart_tx) @(negedge hclk);
        while (!uart_tx) @(negedge hclk);
        n = 0;
        while (uart_tx) begin @(negedge hclk); n++; end
        chk(n == BIT, "R10 bit period", n, BIT);
        repeat (11 * BIT) @(negedge hclk);
        rd(DATA_A, d);
        chk(d == 32'h55, "R5 loopback after timing", d, 32'h55);

        // R3: overfill the transmit queue
        loop = 1'b0;
        for (int i = 0; i < DEPTH + 2; i++) begin
            wr(DATA_A, 8'(8'h10 + i));
            chk(bus_ok, "R3 ready and okay on write", {31'd0, bus_ok}, 32'd1);
        end
        rd(STAT_A, d);
        chk(d == 32'h3, "R2 status tx full", d, 32'h3);
        for (int i = 0; i < DEPTH + 1; i++) begin
            grab(4 * BIT, f, b, p, s, st);
            chk(f && b == 8'(8'h10 + i), "R3 queued bytes kept", {24'd0, b}, {24'd0, 8'(8'h10 + i)});
        end
        grab(22 * BIT, f, b, p, s, st);
        chk(!f, "R3 byte written while full dropped", {31'd0, f}, 32'd0);

        // R9: transfers not qualified have no effect
        bus(1'b1, 2'b00, 1'b1, DATA_A, 32'h77, d);
        bus(1'b1, 2'b01, 1'b1, DATA_A, 32'h78, d);
        bus(1'b0, 2'b10, 1'b1, DATA_A, 32'h79, d);
        grab(13 * BIT, f, b, p, s, st);
        chk(!f, "R9 unqualified writes ignored", {31'd0, f}, 32'd0);
        drive(8'hC6, 1'b0, 1'b1);
        bus(1'b1, 2'b01, 1'b0, DATA_A, 32'h0, d);
        bus(1'b1, 2'b00, 1'b0, DATA_A, 32'h0, d);
        rd(STAT_A, d);
        chk(d == 32'h0, "R9 unqualified reads do not pop", d, 32'h0);
        rd(DATA_A, d);
        chk(d == 32'hC6, "R5 R9 byte still present", d, 32'hC6);

        // R6, R7, R8: frames to be discarded
        drive(8'h3C, 1'b1, 1'b1);
        rd(STAT_A, d);
        chk(d == 32'h1, "R6 bad parity discarded", d, 32'h1);
        drive(8'h5A, 1'b0, 1'b0);
        rd(STAT_A, d);
        chk(d == 32'h1, "R7 bad stop discarded", d, 32'h1);
        @(negedge hclk); bench_rx = 1'b0;
        repeat (BIT / 4) @(negedge hclk);
        bench_rx = 1'b1;
        repeat (12 * BIT) @(negedge hclk);
        rd(STAT_A, d);
        chk(d == 32'h1, "R8 short glitch ignored", d, 32'h1);

        // R5 sweep of received values
        for (int i = 0; i < 24; i++) begin
            v = 8'(i * 37 + 5);
            drive(v, 1'b0, 1'b1);
            rd(DATA_A, d);
            chk(d == {24'd0, v}, "R5 received byte", d, {24'd0, v});
        end
        rd(DATA_A, d);
        chk(d == 32'h0, "R4 empty read after sweep", d, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule